// File: doc/BRIEF.md
# Fractional-Step Waveform Playback Engine

This block plays a waveform table, loaded by software, out towards a DAC. One instance drives one channel, and two instances share no state. A fixed-point read pointer moves through the table. The pointer has an integer part wide enough to index the table plus 16 fractional bits. It advances by a programmable step each time an output sample is accepted, so the playback rate can be set in small increments. Each table sample passes through a linear gain-and-offset stage and is then clamped to the signed 14-bit DAC range.

A small playback state machine has three states: idle, playing and finished. Playback starts on a one-cycle software trigger, or on a rising edge of an external trigger when that source is enabled. Each start emits a single-cycle notification pulse for other subsystems. In wrapping mode the pointer runs modulo the table length for as long as playback lasts. In one-shot mode the pointer stops once it passes the table end. After that the block either repeats the last emitted sample or emits zero.

Output samples leave on a valid/ready stream. Once `dac_valid` is high it stays high, and `dac_data` stays unchanged, until `dac_ready` accepts the sample. The pointer advances only when the output slot is free or is being emptied, so a stalled consumer skips no table entries. The table is written through a plain write port that can be used at any time.

Top module: `wave_player`

## Requirements
- R1: After reset `dac_valid` and `trig_out` are 0 and no sample is produced until a start occurs.
- R2: A start occurs in a cycle where `sw_trig` is 1, or where `ext_en` is 1 and `ext_trig` is 1 after being 0 in the previous cycle. A held-high `ext_trig` starts playback once, and `ext_trig` has no effect while `ext_en` is 0.
- R3: `trig_out` is 1 for exactly the one cycle that follows each start.
- R4: In wrapping mode (`wrap_mode`=1), the k-th sample accepted after a start (k from 0) comes from table entry floor(k*step/65536) modulo the table depth. `step` holds 16 fractional bits in its low bits.
- R5: In one-shot mode (`wrap_mode`=0), samples are emitted for every k with k*step below depth*65536. After that, every later sample equals the last emitted sample when `hold_last`=1, or 0 when `hold_last`=0.
- R6: Each played sample equals floor(s*gain/16384)+offset, where s is the signed table value, `gain` is signed with 14 fractional bits (16384 means 1.0) and `offset` is a signed integer.
- R7: A scaled result above 8191 is output as 8191, and one below -8192 is output as -8192.
- R8: While `dac_valid` is 1 and `dac_ready` is 0, `dac_valid` stays 1 and `dac_data` stays unchanged, and the pointer does not advance.
- R9: After a cycle with `sw_stop`=1, no new sample is produced. A sample already pending stays valid until it is accepted, and `dac_valid` is 0 afterwards.
- R10: A table write and a playback read of the same entry in the same cycle yield the old value. The new value is read on later accesses.
- R11: A start during playback restarts the sequence at table entry 0. A sample already pending is still delivered first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_we | input | 1 | Table write strobe |
| tbl_waddr | input | 6 | Table write index |
| tbl_wdata | input | 14 | Signed sample to store |
| step | input | 22 | Pointer increment, 6 integer and 16 fractional bits |
| wrap_mode | input | 1 | 1 = continuous wrapping, 0 = one-shot |
| hold_last | input | 1 | One-shot end behaviour: 1 repeat last sample, 0 emit zero |
| gain | input | 16 | Signed gain, 14 fractional bits |
| offset | input | 16 | Signed offset added after gain |
| ext_en | input | 1 | Enables the external trigger |
| sw_trig | input | 1 | Software start pulse |
| sw_stop | input | 1 | Return to idle |
| ext_trig | input | 1 | External trigger level, rising edge starts |
| trig_out | output | 1 | One-cycle notification of a start |
| dac_valid | output | 1 | Output sample valid |
| dac_ready | input | 1 | Consumer accepts the sample |
| dac_data | output | 14 | Signed scaled output sample |

## Verification
Two functions can fall in the same cycle here. A table write can land on the exact entry the playback stage reads as a handshake frees the output slot. A restart trigger can arrive while the output holds a sample that has not been accepted. The first case is provoked by raising `dac_ready` for a single cycle together with a write to the next index. The scoreboard then expects the old value for that entry and the new value for a later entry written while stalled. The second case is provoked by re-raising the external trigger with the consumer stalled. The expected queue then holds the stale pending sample followed by the sequence from entry 0.

// File: rtl/wave_pkg.sv
package wave_pkg;
  typedef enum logic [1:0] {
    PB_IDLE = 2'd0,
    PB_PLAY = 2'd1,
    PB_DONE = 2'd2
  } pb_state_e;
endpackage

// File: rtl/wave_table.sv
module wave_table #(
  parameter int IDX_W = 6,
  parameter int DW    = 14
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [IDX_W-1:0]        waddr,
  input  logic signed [DW-1:0]    wdata,
  input  logic [IDX_W-1:0]        raddr,
  output logic signed [DW-1:0]    rdata
);
  localparam int DEPTH = 1 << IDX_W;

  logic signed [DW-1:0] mem [DEPTH];

  // write lands at the edge; a read in the same cycle still sees the old word
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/wave_pointer.sv
module wave_pointer
  import wave_pkg::*;
#(
  parameter int IDX_W  = 6,
  parameter int FRAC_W = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic                      stop,
  input  logic                      advance,
  input  logic                      wrap_mode,
  input  logic [IDX_W+FRAC_W-1:0]   step,
  output logic [IDX_W-1:0]          idx,
  output pb_state_e                 state
);
  localparam int PW = IDX_W + FRAC_W;

  logic [PW-1:0] ptr;
  logic [PW:0]   sum_w;
  logic          past_end;

  assign sum_w    = {1'b0, ptr} + {1'b0, step};
  assign past_end = sum_w[PW];
  assign idx      = ptr[PW-1 -: IDX_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= PB_IDLE;
      ptr   <= '0;
    end else if (start) begin
      state <= PB_PLAY;
      ptr   <= '0;
    end else if (stop) begin
      state <= PB_IDLE;
    end else if (advance && state == PB_PLAY) begin
      if (!wrap_mode && past_end) begin
        state <= PB_DONE;
      end else begin
        ptr <= sum_w[PW-1:0];
      end
    end
  end
endmodule

// File: rtl/wave_scale.sv
module wave_scale #(
  parameter int DW    = 14,
  parameter int GW    = 16,
  parameter int GFRAC = 14,
  parameter int OFW   = 16
) (
  input  logic signed [DW-1:0]  sample,
  input  logic signed [GW-1:0]  gain,
  input  logic signed [OFW-1:0] offset,
  output logic signed [DW-1:0]  result
);
  localparam int PRW = DW + GW;
  localparam int SW  = ((PRW > OFW) ? PRW : OFW) + 1;
  localparam logic signed [SW-1:0] MAXV = {{(SW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [SW-1:0] MINV = {{(SW-DW+1){1'b1}}, {(DW-1){1'b0}}};

  logic signed [PRW-1:0] prod;
  logic signed [PRW-1:0] shifted;
  logic signed [SW-1:0]  sh_x;
  logic signed [SW-1:0]  off_x;
  logic signed [SW-1:0]  sum;

  always_comb begin
    prod    = sample * gain;
    shifted = prod >>> GFRAC;
    sh_x    = shifted;
    off_x   = offset;
    sum     = sh_x + off_x;
    if (sum > MAXV)      result = MAXV[DW-1:0];
    else if (sum < MINV) result = MINV[DW-1:0];
    else                 result = sum[DW-1:0];
  end
endmodule

// File: rtl/wave_player.sv
module wave_player
  import wave_pkg::*;
#(
  parameter int IDX_W  = 6,
  parameter int FRAC_W = 16,
  parameter int DW     = 14,
  parameter int GW     = 16,
  parameter int GFRAC  = 14,
  parameter int OFW    = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     tbl_we,
  input  logic [IDX_W-1:0]         tbl_waddr,
  input  logic signed [DW-1:0]     tbl_wdata,
  input  logic [IDX_W+FRAC_W-1:0]  step,
  input  logic                     wrap_mode,
  input  logic                     hold_last,
  input  logic signed [GW-1:0]     gain,
  input  logic signed [OFW-1:0]    offset,
  input  logic                     ext_en,
  input  logic                     sw_trig,
  input  logic                     sw_stop,
  input  logic                     ext_trig,
  output logic                     trig_out,
  output logic                     dac_valid,
  input  logic                     dac_ready,
  output logic signed [DW-1:0]     dac_data
);
  logic                 ext_q;
  logic                 ext_rise;
  logic                 start;
  logic                 slot_free;
  logic                 fire;
  logic [IDX_W-1:0]     rd_idx;
  logic signed [DW-1:0] rd_word;
  logic signed [DW-1:0] scaled;
  logic signed [DW-1:0] last_q;
  logic signed [DW-1:0] next_word;
  pb_state_e            pb_state;

  assign ext_rise  = ext_en && ext_trig && !ext_q;
  assign start     = sw_trig || ext_rise;
  assign slot_free = !dac_valid || dac_ready;
  assign fire      = (pb_state != PB_IDLE) && !start && !sw_stop && slot_free;

  wave_table #(.IDX_W(IDX_W), .DW(DW)) u_table (
    .clk   (clk),
    .we    (tbl_we),
    .waddr (tbl_waddr),
    .wdata (tbl_wdata),
    .raddr (rd_idx),
    .rdata (rd_word)
  );

  wave_pointer #(.IDX_W(IDX_W), .FRAC_W(FRAC_W)) u_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .stop      (sw_stop),
    .advance   (fire),
    .wrap_mode (wrap_mode),
    .step      (step),
    .idx       (rd_idx),
    .state     (pb_state)
  );

  wave_scale #(.DW(DW), .GW(GW), .GFRAC(GFRAC), .OFW(OFW)) u_scale (
    .sample (rd_word),
    .gain   (gain),
    .offset (offset),
    .result (scaled)
  );

  always_comb begin
    if (pb_state == PB_PLAY) next_word = scaled;
    else if (hold_last)      next_word = last_q;
    else                     next_word = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ext_q     <= 1'b0;
      trig_out  <= 1'b0;
      dac_valid <= 1'b0;
      dac_data  <= '0;
      last_q    <= '0;
    end else begin
      ext_q    <= ext_trig;
      trig_out <= start;
      if (fire) begin
        dac_valid <= 1'b1;
        dac_data  <= next_word;
        if (pb_state == PB_PLAY) last_q <= scaled;
      end else if (dac_ready) begin
        dac_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/wave_player_chk.sv
module wave_player_chk #(
  parameter int DW = 14
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 ext_en,
  input logic                 ext_trig,
  input logic                 sw_trig,
  input logic                 sw_stop,
  input logic                 trig_out,
  input logic                 dac_valid,
  input logic                 dac_ready,
  input logic signed [DW-1:0] dac_data
);
  // R8: stalled output keeps valid and data
  a_r8_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    dac_valid && !dac_ready |=> dac_valid && $stable(dac_data));

  // R3: a notification pulse needs a trigger source in the cycle before
  a_r3_trig_cause: assert property (@(posedge clk) disable iff (!rst_n)
    trig_out |-> $past(sw_trig || (ext_en && ext_trig)));

  // R2: with the external source disabled and no software pulse, no start
  a_r2_ext_off: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_en && !sw_trig |=> !trig_out);

  // R9: a stop with an empty or draining output leaves no valid sample
  a_r9_stop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    sw_stop && !sw_trig && !ext_en && (!dac_valid || dac_ready) |=> !dac_valid);
endmodule

bind wave_player wave_player_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ext_en    (ext_en),
  .ext_trig  (ext_trig),
  .sw_trig   (sw_trig),
  .sw_stop   (sw_stop),
  .trig_out  (trig_out),
  .dac_valid (dac_valid),
  .dac_ready (dac_ready),
  .dac_data  (dac_data)
);

// File: tb/test_wave_player.sv
module test_wave_player;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 64;

  logic clk = 0;
  logic rst_n = 0;
  logic tbl_we = 0;
  logic [5:0] tbl_waddr = '0;
  logic signed [13:0] tbl_wdata = '0;
  logic [21:0] step = '0;
  logic wrap_mode = 1;
  logic hold_last = 0;
  logic signed [15:0] gain = 16'sh4000;
  logic signed [15:0] offset = '0;
  logic ext_en = 0, sw_trig = 0, sw_stop = 0, ext_trig = 0;
  logic trig_out, dac_valid;
  logic dac_ready = 0;
  logic signed [13:0] dac_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  wave_player i_wave_player (
    .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_waddr(tbl_waddr),
    .tbl_wdata(tbl_wdata), .step(step), .wrap_mode(wrap_mode),
    .hold_last(hold_last), .gain(gain), .offset(offset), .ext_en(ext_en),
    .sw_trig(sw_trig), .sw_stop(sw_stop), .ext_trig(ext_trig),
    .trig_out(trig_out), .dac_valid(dac_valid), .dac_ready(dac_ready),
    .dac_data(dac_data));

  int total = 0, bad = 0, hs = 0;
  int tm [DEPTH];
  int expq [$];
  string tagq [$];
  bit done = 0;

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  function automatic int scale_model(int s);
    longint p;
    p = longint'(s) * longint'(gain);
    p = p >>> 14;
    p = p + longint'(offset);
    if (p > 8191) p = 8191;
    if (p < -8192) p = -8192;
    return int'(p);
  endfunction

  function automatic int idx_of(longint k, longint st);
    return int'(((k * st) >> 16) % DEPTH);
  endfunction

  // scoreboard monitor: a handshake is seen at negedge, transfers at the next posedge
  always @(negedge clk) begin
    if (rst_n && dac_valid && dac_ready) begin
      hs++;
      if (expq.size() == 0) begin
        check(0, "unexpected sample", int'(dac_data), 0);
      end else begin
        int e;
        string t;
        e = expq.pop_front();
        t = tagq.pop_front();
        check(int'(dac_data) == e, t, int'(dac_data), e);
      end
    end
  end

  task automatic push(int v, string t);
    expq.push_back(v);
    tagq.push_back(t);
  endtask

  task automatic push_run(longint st, int k0, int n, string t);
    for (int k = k0; k < k0 + n; k++) push(scale_model(tm[idx_of(k, st)]), t);
  endtask

  task automatic consume(int n);
    int target;
    target = hs + n;
    dac_ready = 1;
    while (hs < target) tick();
    dac_ready = 0;
    check(expq.size() == 0, "scoreboard drained", expq.size(), 0);
  endtask

  task automatic write_tbl(int a, int v);
    tick();
    tbl_we = 1; tbl_waddr = 6'(a); tbl_wdata = 14'(v);
    tick();
    tbl_we = 0;
    tm[a] = v;
  endtask

  task automatic pulse_sw();
    tick(); sw_trig = 1;
    tick(); sw_trig = 0;
    @(negedge clk); check(trig_out == 1, "R3 pulse high", int'(trig_out), 1);
    @(negedge clk); check(trig_out == 0, "R3 pulse single", int'(trig_out), 0);
  endtask

  task automatic stop_drain(int e, string t);
    tick(); sw_stop = 1;
    tick(); sw_stop = 0;
    push(e, t);
    consume(1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); check(dac_valid == 0, "R9 quiet after stop", int'(dac_valid), 0);
    end
  endtask

  task automatic oneshot(longint st, int extra, string t);
    int k, last;
    k = 0; last = 0;
    while (longint'(k) * st < longint'(DEPTH) * 65536) begin
      last = scale_model(tm[idx_of(k, st)]);
      push(last, t);
      k++;
    end
    for (int i = 0; i < extra; i++) push(hold_last ? last : 0, t);
    pulse_sw();
    consume(k + extra);
    stop_drain(hold_last ? last : 0, t);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      check(0, "watchdog", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int cnt, held, old1;
    repeat (5) tick();
    // R1: reset state
    @(negedge clk);
    check(dac_valid == 0, "R1 valid in reset", int'(dac_valid), 0);
    rst_n = 1;
    tick();
    @(negedge clk);
    check(dac_valid == 0, "R1 valid after reset", int'(dac_valid), 0);
    check(trig_out == 0, "R1 trig after reset", int'(trig_out), 0);

    for (int i = 0; i < DEPTH; i++) write_tbl(i, ((i * 523) % 16384) - 8192);

    // R4 wrapping playback with fractional step 1.5, plus R8 stall
    wrap_mode = 1; step = 22'h18000;
    pulse_sw();
    push_run(64'h18000, 0, 40, "R4 wrap 1.5");
    consume(40);
    @(negedge clk); held = int'(dac_data);
    repeat (3) @(negedge clk);
    check(dac_valid == 1, "R8 valid held", int'(dac_valid), 1);
    check(int'(dac_data) == held, "R8 data stable", int'(dac_data), held);
    check(held == scale_model(tm[idx_of(40, 64'h18000)]), "R8 no skip", held,
          scale_model(tm[idx_of(40, 64'h18000)]));
    stop_drain(held, "R9 pending kept");

    // R5 one-shot, hold last, step 2.5
    wrap_mode = 0; hold_last = 1; step = 22'h28000;
    oneshot(64'h28000, 3, "R5 oneshot hold");
    // R5 one-shot, zero after end, step 16.0
    hold_last = 0; step = 22'h100000;
    oneshot(64'h100000, 2, "R5 oneshot zero");

    // R6 and R7: negative gain, offset, saturation both ways
    wrap_mode = 1; step = 22'h10000; gain = -16'sd32768; offset = 16'sd100;
    pulse_sw();
    push_run(64'h10000, 0, 64, "R6 R7 gain -2");
    consume(64);
    stop_drain(scale_model(tm[0]), "R6 R7 gain -2");
    gain = 16'sh6000; offset = 16'sd3000;
    pulse_sw();
    push_run(64'h10000, 0, 64, "R6 R7 gain 1.5");
    consume(64);
    stop_drain(scale_model(tm[0]), "R6 R7 gain 1.5");
    gain = 16'sh4000; offset = 0;

    // R2: external trigger ignored while disabled
    tick(); ext_trig = 1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(trig_out == 0, "R2 ext disabled trig", int'(trig_out), 0);
      check(dac_valid == 0, "R2 ext disabled valid", int'(dac_valid), 0);
    end
    tick(); ext_trig = 0;
    tick(); ext_en = 1;
    tick(); ext_trig = 1;
    cnt = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); if (trig_out) cnt++;
    end
    check(cnt == 1, "R2 held ext starts once", cnt, 1);
    push_run(64'h10000, 0, 5, "R2 ext start");
    consume(5);
    // R11: restart with a pending sample
    tick(); ext_trig = 0;
    tick(); ext_trig = 1;
    push(scale_model(tm[5]), "R11 pending first");
    push_run(64'h10000, 0, 4, "R11 restart at 0");
    consume(5);
    stop_drain(scale_model(tm[4]), "R11 restart at 0");
    ext_trig = 0; ext_en = 0;

    // R10: write and read of the same entry in one cycle
    pulse_sw();
    repeat (2) tick();
    push(scale_model(tm[0]), "R10 entry 0");
    old1 = tm[1];
    tbl_we = 1; tbl_waddr = 6'd1; tbl_wdata = 14'sd1234; dac_ready = 1;
    tick();
    tbl_we = 0; dac_ready = 0;
    tm[1] = 1234;
    write_tbl(2, -4321);
    push(scale_model(old1), "R10 old value on collision");
    push(scale_model(tm[2]), "R10 new value later");
    consume(2);
    stop_drain(scale_model(tm[3]), "R10 entry 3");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule